// File: doc/BRIEF.md
# Voltage-ID Code Capture

This block turns four slow, asynchronous voltage-identification lines into a 6-bit code for a current DAC. Three of the lines carry data. The fourth is either a strobe or a fourth data bit, depending on a mode input. Each line is brought into the clock domain by a two-flop synchroniser. It then passes a stable-time filter whose length is counted in system clocks, with the clocks-per-microsecond rate set by a parameter.

In strobe mode the strobe's falling edge takes the three data lines as the low half of the word. Its rising edge takes them as the high half and commits the whole 6-bit word to the output. The strobe's rising path uses a longer filter, so data lines that switch together with the strobe are taken at their new value. In parallel mode the four lines form one 4-bit value n. Any filtered change on any of the four lines commits the 6-bit code 4·n+3.

While the block is disabled or in undervoltage, the output-enable flag is low. During that time the code is loaded from a 4-bit start-up input, mapped the same way. On release, the start-up code stays on the output until the first command arrives.

Top module: `vid_capture`

## Requirements
- R1: `mode_sel` = 0 selects strobe (6-bit) mode and `mode_sel` = 1 selects parallel (4-bit) mode. The mode is latched only while the block is held (in reset, disabled or in undervoltage). A change while running has no effect until the next hold.
- R2: In strobe mode, a filtered falling edge of `vid_s` stores `vid_a`, `vid_b` and `vid_c` as code bits 0, 1 and 2, and leaves `code_out` unchanged.
- R3: In strobe mode, a filtered rising edge of `vid_s` commits `code_out` = {`vid_c`,`vid_b`,`vid_a`,stored low half}, so that `vid_a` lands on bit 3 and `vid_c` on bit 5.
- R4: A level on any line that lasts fewer than DGL_US·CLK_PER_US clocks is ignored and does not change `code_out`.
- R5: The strobe's rising edge is filtered for STRB_RISE_US·CLK_PER_US clocks. Data lines that change in the same cycle as the strobe rises are therefore captured at their new value.
- R6: In parallel mode, the value n = {`vid_s`,`vid_c`,`vid_b`,`vid_a`} is committed as `code_out` = 4·n+3 after any filtered change on any line. For example, 0 maps to 3 and 15 maps to 63.
- R7: While `enable` is low or `uvlo` is high: from the next clock on, `out_en` is 0, `code_out` equals 4·`startup_code`+3, and the stored low half is cleared to 0.
- R8: After a hold is released, `out_en` rises and the start-up code stays on `code_out` until the first command in either mode.
- R9: `code_upd` pulses high for exactly the clock in which a newly committed code first appears, while `out_en` is 1. While enabled, `code_out` never changes without this pulse.
- R10: While `rst_n` is low, `code_out`, `out_en` and `code_upd` are 0. The first clock after reset loads the start-up code with `out_en` still 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable, synchronous; low holds the block |
| uvlo | input | 1 | Undervoltage flag, synchronous; high holds the block |
| mode_sel | input | 1 | 0 strobe (6-bit) mode, 1 parallel (4-bit) mode |
| vid_a | input | 1 | Asynchronous data line A |
| vid_b | input | 1 | Asynchronous data line B |
| vid_c | input | 1 | Asynchronous data line C |
| vid_s | input | 1 | Asynchronous strobe line, or bit 3 in parallel mode |
| startup_code | input | 4 | Start-up 4-bit code loaded while held |
| code_out | output | 6 | Committed 6-bit DAC code |
| out_en | output | 1 | DAC output enable |
| code_upd | output | 1 | One-clock pulse on each commit |

## Verification
The bench builds the block with CLK_PER_US = 4, which gives a 12-clock data filter and a 24-clock strobe-rise filter. With these values, every filter threshold, every glitch shorter than a threshold and every full two-phase strobe transfer fits in a few dozen cycles. The run can therefore compare against a cycle-exact model on every clock. It covers both modes, a mode change while running, holds from both the enable and the undervoltage inputs, and the clearing of the low half across a hold.

// File: rtl/vid_capture.sv
module vid_capture #(
  parameter int CLK_PER_US   = 100,
  parameter int DGL_US       = 3,
  parameter int STRB_RISE_US = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       uvlo,
  input  logic       mode_sel,
  input  logic       vid_a,
  input  logic       vid_b,
  input  logic       vid_c,
  input  logic       vid_s,
  input  logic [3:0] startup_code,
  output logic [5:0] code_out,
  output logic       out_en,
  output logic       code_upd
);
  localparam int DGL_CNT  = CLK_PER_US * DGL_US;
  localparam int RISE_CNT = CLK_PER_US * STRB_RISE_US;
  localparam int CW       = $clog2(RISE_CNT + 1);
  localparam logic [CW-1:0] DGL_M1  = CW'(DGL_CNT - 1);
  localparam logic [CW-1:0] RISE_M1 = CW'(RISE_CNT - 1);

  logic [3:0] raw, s1, s2, lv, lvd, ev;
  logic [2:0] lo_q;
  logic       mode_q, armed;

  assign raw = {vid_s, vid_c, vid_b, vid_a};
  assign ev  = lv ^ lvd;

  wire hold = !enable || uvlo;
  wire held = hold || !armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar g = 0; g < 4; g++) begin : g_flt
    logic [CW-1:0] cnt;
    logic          lvl;
    wire  [CW-1:0] lim = (g == 3 && !mode_q && s2[g]) ? RISE_M1 : DGL_M1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (s2[g] == lvl) begin
        cnt <= '0;
      end else if (cnt == lim) begin
        lvl <= s2[g];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end

    assign lv[g] = lvl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_out <= '0;
      out_en   <= 1'b0;
      code_upd <= 1'b0;
      lo_q     <= '0;
      mode_q   <= 1'b0;
      armed    <= 1'b0;
      lvd      <= '0;
    end else begin
      lvd      <= lv;
      armed    <= 1'b1;
      out_en   <= !held;
      code_upd <= 1'b0;
      if (held) begin
        code_out <= {startup_code, 2'b11};
        lo_q     <= '0;
        mode_q   <= mode_sel;
      end else if (!mode_q) begin
        if (ev[3] && !lv[3]) lo_q <= lv[2:0];
        if (ev[3] && lv[3]) begin
          code_out <= {lv[2:0], lo_q};
          code_upd <= 1'b1;
        end
      end else if (|ev) begin
        code_out <= {lv, 2'b11};
        code_upd <= 1'b1;
      end
    end
endmodule

module vid_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       uvlo,
  input logic [3:0] startup_code,
  input logic [5:0] code_out,
  input logic       out_en,
  input logic       code_upd,
  input logic       mode_q,
  input logic       strobe_lvl
);
  p_hold_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || uvlo) |=> (!out_en && code_out == {$past(startup_code), 2'b11}));

  p_no_silent_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && $past(out_en) && !code_upd) |-> $stable(code_out));

  p_upd_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_upd |-> out_en);

  p_parallel_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_upd && mode_q) |-> (code_out[1:0] == 2'b11));

  p_strobe_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_upd && !mode_q) |-> strobe_lvl);
endmodule

bind vid_capture vid_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .uvlo(uvlo),
  .startup_code(startup_code), .code_out(code_out), .out_en(out_en),
  .code_upd(code_upd), .mode_q(mode_q), .strobe_lvl(lv[3])
);

// File: tb/vid_capture_tb_top.sv
module vid_capture_tb_top;
  localparam int CPU  = 4;
  localparam int DGL  = CPU * 3;
  localparam int RISE = CPU * 6;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, uvlo = 1'b0, mode_sel = 1'b0;
  logic vid_a = 1'b0, vid_b = 1'b0, vid_c = 1'b0, vid_s = 1'b0;
  logic [3:0] startup_code = 4'd5;
  logic [5:0] code_out;
  logic out_en, code_upd;

  vid_capture #(.CLK_PER_US(CPU), .DGL_US(3), .STRB_RISE_US(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uvlo(uvlo), .mode_sel(mode_sel),
    .vid_a(vid_a), .vid_b(vid_b), .vid_c(vid_c), .vid_s(vid_s),
    .startup_code(startup_code), .code_out(code_out), .out_en(out_en),
    .code_upd(code_upd));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, upd_seen = 0;
  bit done = 1'b0;

  // behavioural reference
  bit        hist [4][32];
  bit  [3:0] m_lv, m_lvd, m_nlv, m_ev, m_raw;
  bit  [2:0] m_lo;
  bit  [5:0] m_code;
  bit        m_oen, m_upd, m_mode, m_armed, m_held;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (code_upd) upd_seen++;
    if (!rst_n) begin
      m_lv = '0; m_lvd = '0; m_lo = '0; m_code = '0; m_oen = 0; m_upd = 0;
      m_mode = 0; m_armed = 0;
      for (int l = 0; l < 4; l++) for (int i = 0; i < 32; i++) hist[l][i] = 1'b0;
    end else begin
      m_raw  = {vid_s, vid_c, vid_b, vid_a};
      m_held = !m_armed || !enable || uvlo;
      m_ev   = m_lv ^ m_lvd;
      m_nlv  = m_lv;
      for (int l = 0; l < 4; l++) begin
        int  n;
        bit  all;
        n   = (l == 3 && !m_mode && !m_lv[3]) ? RISE : DGL;
        all = 1'b1;
        for (int i = 1; i <= n; i++) if (hist[l][i] == m_lv[l]) all = 1'b0;
        if (all) m_nlv[l] = ~m_lv[l];
      end
      m_upd = 1'b0;
      if (m_held) begin
        m_code = {startup_code, 2'b11}; m_lo = '0; m_mode = mode_sel;
      end else if (!m_mode) begin
        if (m_ev[3] && m_lv[3]) begin m_code = {m_lv[2:0], m_lo}; m_upd = 1'b1; end
        if (m_ev[3] && !m_lv[3]) m_lo = m_lv[2:0];
      end else if (m_ev != 0) begin
        m_code = {m_lv, 2'b11}; m_upd = 1'b1;
      end
      m_oen   = !m_held;
      m_armed = 1'b1;
      m_lvd   = m_lv;
      m_lv    = m_nlv;
      for (int l = 0; l < 4; l++) begin
        for (int i = 31; i > 0; i--) hist[l][i] = hist[l][i-1];
        hist[l][0] = m_raw[l];
      end
    end
    #1;
    chk("R9 model code_upd", code_upd, m_upd);
    chk("R6 model code_out", code_out, m_code);
    chk("R8 model out_en", out_en, m_oen);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int u0;
    cyc(3);
    chk("R10 reset code_out", code_out, 0);
    chk("R10 reset out_en", out_en, 0);
    chk("R10 reset code_upd", code_upd, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R8 startup code", code_out, 23);
    chk("R8 out_en after release", out_en, 1);
    // simultaneous data and strobe rise
    u0 = upd_seen;
    {vid_c, vid_b, vid_a} = 3'b110; vid_s = 1'b1;
    cyc(8);
    chk("R8 startup held before command", code_out, 23);
    cyc(40);
    chk("R5 R3 simultaneous rise captures new data", code_out, 48);
    chk("R9 one pulse per commit", upd_seen - u0, 1);
    // two-phase transfer
    {vid_c, vid_b, vid_a} = 3'b101; cyc(20);
    vid_s = 1'b0; cyc(40);
    chk("R2 falling edge does not commit", code_out, 48);
    {vid_c, vid_b, vid_a} = 3'b011; cyc(20);
    vid_s = 1'b1; cyc(40);
    chk("R3 R2 full word commit", code_out, 29);
    // mode change while running
    mode_sel = 1'b1; cyc(5);
    vid_a = 1'b0; cyc(40);
    chk("R1 mode change while running ignored", code_out, 29);
    vid_a = 1'b1; cyc(40);
    // strobe glitch
    vid_s = 1'b0; cyc(5); vid_s = 1'b1; cyc(40);
    chk("R4 short strobe glitch ignored", code_out, 29);
    // hold by enable
    enable = 1'b0; startup_code = 4'd9; cyc(3);
    chk("R7 disabled out_en", out_en, 0);
    chk("R7 disabled startup code", code_out, 39);
    enable = 1'b1; cyc(40);
    chk("R8 out_en restored", out_en, 1);
    chk("R8 startup kept until command", code_out, 39);
    // parallel mode
    vid_a = 1'b0; cyc(40);
    chk("R6 parallel value 10", code_out, 43);
    vid_b = 1'b0; cyc(5); vid_b = 1'b1; cyc(40);
    chk("R4 short data glitch ignored", code_out, 43);
    {vid_s, vid_c, vid_b, vid_a} = 4'hF; cyc(40);
    chk("R6 parallel value 15", code_out, 63);
    {vid_s, vid_c, vid_b, vid_a} = 4'h0; cyc(40);
    chk("R6 parallel value 0", code_out, 3);
    // hold by undervoltage, back to strobe mode
    uvlo = 1'b1; mode_sel = 1'b0; startup_code = 4'd15; cyc(3);
    chk("R7 uvlo startup code", code_out, 63);
    chk("R7 uvlo out_en", out_en, 0);
    uvlo = 1'b0; cyc(40);
    {vid_c, vid_b, vid_a} = 3'b111; vid_s = 1'b1; cyc(50);
    chk("R7 R1 low half cleared, strobe mode restored", code_out, 56);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule